// File: doc/BRIEF.md
# PCIe Configuration Access Router

This block sits between a root-complex host's configuration-access requests and the two regions where configuration space can be reached. A request carries a bus number, a device number, a function number and a register offset. Requests for bus 0 are sent straight to the local configuration space. Requests for every other bus are sent through a remote window that sits a fixed distance above the local base. Before such a request leaves, the block loads a target-ID setup register that the downstream logic reads to route it. The block produces the chosen region, the setup word it formed, and a dword-aligned address.

Bus 1 is handled as a virtual secondary bus, so it uses a Type 0 access. Only buses 2 and above are marked Type 1. A small register port lets software read the setup register and control the command word, whose bit 0 starts link training. The block also reports link-up when the link-training state field reaches the active state.

Top module: `cfg_access_router`

## Requirements
- R1: A request for bus 0 reports the local region (`acc_remote`=0), outputs a setup word of 0, and leaves the setup register unchanged.
- R2: A request for a bus other than 0 reports the remote region and forms the setup word with bus in bits 23:16, device in bits 12:8, function in bits 2:0, and all other bits zero except bit 24.
- R3: Setup bit 24 (Type 1) is 1 when the bus number is 2 or higher, and 0 for bus 1.
- R4: The local address is LOCAL_BASE plus the aligned offset. The remote address is LOCAL_BASE + 0x1000 plus the aligned offset.
- R5: The offset is aligned to a dword: bits 1:0 of the output address are always 0, and the offset's other bits pass through unchanged.
- R6: Device inputs are masked to 5 bits and function inputs to 3 bits, so higher input bits have no effect on the setup word.
- R7: The setup register takes the new value on the clock edge that accepts a remote request. `acc_valid`, `acc_remote`, `acc_addr` and `acc_setup` appear one edge later, for exactly one cycle per request. Back-to-back requests are accepted on every cycle.
- R8: A register read at offset 0x008 returns the setup register on `reg_rdata` after the next edge, as it was before that edge. Register writes to 0x008 are ignored. `reg_rdata` holds its value when no read is made, and reads of other unused offsets return 0.
- R9: Register offset 0x004 is the command word. Bit 0 can be written and read back, and it drives `train_en`.
- R10: `link_up` is 1 one cycle after the low 5 bits of `dbg_status` equal 0x11, and 0 otherwise. The upper bits of `dbg_status` are ignored.
- R11: While `rst_n` is low at a clock edge, every output and the setup register return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Configuration request present this cycle |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 8 | Target device (low 5 bits used) |
| req_fn | input | 8 | Target function (low 3 bits used) |
| req_off | input | 12 | Register offset in the function's space |
| acc_valid | output | 1 | Routed access present |
| acc_remote | output | 1 | 1 = remote window, 0 = local space |
| acc_addr | output | 32 | Dword-aligned access address |
| acc_setup | output | 32 | Setup word formed for this access (0 when local) |
| reg_rd | input | 1 | Register-port read strobe |
| reg_wr | input | 1 | Register-port write strobe |
| reg_addr | input | 12 | Register-port byte offset |
| reg_wdata | input | 32 | Register-port write data |
| reg_rdata | output | 32 | Register-port read data, registered |
| dbg_status | input | 32 | Debug status word carrying the link-training state |
| train_en | output | 1 | Link-training enable (command bit 0) |
| link_up | output | 1 | Link is in the active state |

## Verification
A register read of the setup register and a remote request that rewrites it can land in the same cycle. The read must return the value from before that edge, and a second read then returns the new one. The bench drives both strobes on one clock. It compares the first read against the old setup word and the follow-up read against the word formed from the request. A write to the setup offset is also issued in the middle of the request traffic and then read back, to confirm the write changed nothing.

// File: rtl/cfgr_pkg.sv
// Package: shared widths, setup-word field positions and the routed-access
// record used between the decoder and the output pipeline.
package cfgr_pkg;
    localparam int BUS_W     = 8;   // bus number width
    localparam int DEV_W     = 5;   // device field width
    localparam int FN_W      = 3;   // function field width
    localparam int ID_IN_W   = 8;   // raw width of device/function inputs
    localparam int OFF_W     = 12;  // register offset width
    localparam int AW        = 32;  // address width
    localparam int DW        = 32;  // data / setup word width
    localparam int BUS_LSB   = 16;  // bus field position in setup word
    localparam int DEV_LSB   = 8;   // device field position
    localparam int FN_LSB    = 0;   // function field position
    localparam int TYPE1_BIT = 24;  // set for Type 1 accesses

    typedef struct packed {
        logic          remote;
        logic [AW-1:0] addr;
        logic [DW-1:0] setup;
    } cfg_acc_t;

    // Builds the setup word from target id and access type.
    function automatic logic [DW-1:0] form_setup(
        input logic [BUS_W-1:0] bus,
        input logic [DEV_W-1:0] dev,
        input logic [FN_W-1:0]  fn,
        input logic             type1
    );
        logic [DW-1:0] w;
        w = '0;
        w[BUS_LSB +: BUS_W] = bus;
        w[DEV_LSB +: DEV_W] = dev;
        w[FN_LSB  +: FN_W]  = fn;
        w[TYPE1_BIT]        = type1;
        return w;
    endfunction
endpackage

// File: rtl/cfgr_decode.sv
// Module: cfgr_decode
// Combinational route decision for one configuration request: picks the
// region, forms the setup word and the dword-aligned address.
// Assumes: the remote window lies REMOTE_OFS above LOCAL_BASE; bus 0 is local.
module cfgr_decode
    import cfgr_pkg::*;
#(
    parameter logic [AW-1:0] LOCAL_BASE = '0,
    parameter logic [AW-1:0] REMOTE_OFS = 32'h0000_1000
) (
    input  logic [BUS_W-1:0]   bus,
    input  logic [ID_IN_W-1:0] dev_in,
    input  logic [ID_IN_W-1:0] fn_in,
    input  logic [OFF_W-1:0]   off,
    output cfg_acc_t           acc
);
    localparam logic [AW-1:0] REMOTE_BASE = LOCAL_BASE + REMOTE_OFS;

    logic [DEV_W-1:0] dev;
    logic [FN_W-1:0]  fn;
    logic             is_remote;
    logic             is_type1;
    logic [AW-1:0]    aligned;

    // Upper id bits are deliberately dropped by masking.
    logic unused_id_bits;
    assign unused_id_bits = &{1'b0, dev_in[ID_IN_W-1:DEV_W], fn_in[ID_IN_W-1:FN_W]};

    // Mask id fields, classify the bus, align the offset and build the record.
    always_comb begin
        dev       = dev_in[DEV_W-1:0];
        fn        = fn_in[FN_W-1:0];
        is_remote = (bus != '0);
        is_type1  = (bus > BUS_W'(1));
        aligned   = '0;
        aligned[OFF_W-1:2] = off[OFF_W-1:2];
        acc.remote = is_remote;
        acc.addr   = (is_remote ? REMOTE_BASE : LOCAL_BASE) + aligned;
        acc.setup  = is_remote ? form_setup(bus, dev, fn, is_type1) : '0;
    end
endmodule

// File: rtl/cfgr_pipe.sv
// Module: cfgr_pipe
// Fixed-depth register pipeline that carries a routed access to the output.
// Assumes: DEPTH >= 1; every stage advances every cycle (no back-pressure).
module cfgr_pipe
    import cfgr_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     in_valid,
    input  cfg_acc_t in_acc,
    output logic     out_valid,
    output cfg_acc_t out_acc
);
    logic     vld [DEPTH];
    cfg_acc_t stg [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        // Advance one stage of the access record, cleared on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld[g] <= 1'b0;
                stg[g] <= '0;
            end else if (g == 0) begin
                vld[g] <= in_valid;
                stg[g] <= in_valid ? in_acc : '0;
            end else begin
                vld[g] <= vld[(g == 0) ? 0 : g-1];
                stg[g] <= stg[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign out_valid = vld[DEPTH-1];
    assign out_acc   = stg[DEPTH-1];
endmodule

// File: rtl/cfgr_regs.sv
// Module: cfgr_regs
// Holds the setup register and command word, serves register-port reads and
// senses the link state.
// Assumes: a request update and a port read in one cycle see the old value;
// port writes to the setup offset are dropped.
module cfgr_regs
    import cfgr_pkg::*;
#(
    parameter int             RA_W       = 12,
    parameter logic [RA_W-1:0] SETUP_ADDR = 12'h008,
    parameter logic [RA_W-1:0] CMD_ADDR   = 12'h004,
    parameter int             ST_W       = 5,
    parameter logic [ST_W-1:0] L0_CODE    = 5'h11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd,
    input  logic [DW-1:0]   upd_val,
    input  logic            reg_rd,
    input  logic            reg_wr,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic [DW-1:0]   dbg_status,
    output logic [DW-1:0]   setup_q,
    output logic            train_en,
    output logic            link_up
);
    logic unused_bits;
    assign unused_bits = &{1'b0, reg_wdata[DW-1:1], dbg_status[DW-1:ST_W]};

    logic [DW-1:0] rd_mux;

    // Select the read value from the current (pre-edge) register contents.
    always_comb begin
        rd_mux = '0;
        if (reg_addr == SETUP_ADDR)
            rd_mux = setup_q;
        else if (reg_addr == CMD_ADDR)
            rd_mux[0] = train_en;
    end

    // Setup register: loaded only by remote requests.
    always_ff @(posedge clk) begin
        if (!rst_n)
            setup_q <= '0;
        else if (upd)
            setup_q <= upd_val;
    end

    // Command word bit 0: link-training enable, written from the port.
    always_ff @(posedge clk) begin
        if (!rst_n)
            train_en <= 1'b0;
        else if (reg_wr && reg_addr == CMD_ADDR)
            train_en <= reg_wdata[0];
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_rd)
            reg_rdata <= rd_mux;
    end

    // Link-up flag from the training-state field.
    always_ff @(posedge clk) begin
        if (!rst_n)
            link_up <= 1'b0;
        else
            link_up <= (dbg_status[ST_W-1:0] == L0_CODE);
    end
endmodule

// File: rtl/cfg_access_router.sv
// Module: cfg_access_router (top)
// Routes configuration requests to local or remote space, loads the setup
// register one cycle ahead of the access output, and exposes the register port.
// Assumes: one request per cycle at most; no back-pressure from downstream.
module cfg_access_router
    import cfgr_pkg::*;
#(
    parameter logic [AW-1:0]   LOCAL_BASE = '0,
    parameter logic [AW-1:0]   REMOTE_OFS = 32'h0000_1000,
    parameter int              RA_W       = 12,
    parameter logic [RA_W-1:0] SETUP_ADDR = 12'h008,
    parameter logic [RA_W-1:0] CMD_ADDR   = 12'h004,
    parameter int              ST_W       = 5,
    parameter logic [ST_W-1:0] L0_CODE    = 5'h11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [BUS_W-1:0]   req_bus,
    input  logic [ID_IN_W-1:0] req_dev,
    input  logic [ID_IN_W-1:0] req_fn,
    input  logic [OFF_W-1:0]   req_off,
    output logic               acc_valid,
    output logic               acc_remote,
    output logic [AW-1:0]      acc_addr,
    output logic [DW-1:0]      acc_setup,
    input  logic               reg_rd,
    input  logic               reg_wr,
    input  logic [RA_W-1:0]    reg_addr,
    input  logic [DW-1:0]      reg_wdata,
    output logic [DW-1:0]      reg_rdata,
    input  logic [DW-1:0]      dbg_status,
    output logic               train_en,
    output logic               link_up
);
    localparam int PIPE_DEPTH = 2;  // setup write leads the access by one edge

    cfg_acc_t      dec_acc;
    cfg_acc_t      out_acc;
    logic [DW-1:0] setup_q;
    logic          setup_upd;

    cfgr_decode #(.LOCAL_BASE(LOCAL_BASE), .REMOTE_OFS(REMOTE_OFS)) u_dec (
        .bus    (req_bus),
        .dev_in (req_dev),
        .fn_in  (req_fn),
        .off    (req_off),
        .acc    (dec_acc)
    );

    assign setup_upd = req_valid && dec_acc.remote;

    cfgr_pipe #(.DEPTH(PIPE_DEPTH)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .in_acc    (dec_acc),
        .out_valid (acc_valid),
        .out_acc   (out_acc)
    );

    cfgr_regs #(
        .RA_W(RA_W), .SETUP_ADDR(SETUP_ADDR), .CMD_ADDR(CMD_ADDR),
        .ST_W(ST_W), .L0_CODE(L0_CODE)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd        (setup_upd),
        .upd_val    (dec_acc.setup),
        .reg_rd     (reg_rd),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .dbg_status (dbg_status),
        .setup_q    (setup_q),
        .train_en   (train_en),
        .link_up    (link_up)
    );

    assign acc_remote = out_acc.remote;
    assign acc_addr   = out_acc.addr;
    assign acc_setup  = out_acc.setup;
endmodule

// File: rtl/cfgr_chk.sv
// Module: cfgr_chk
// Property checker bound to cfg_access_router; observes ports and the setup
// register only.
module cfgr_chk
    import cfgr_pkg::*;
#(
    parameter int              RA_W       = 12,
    parameter logic [RA_W-1:0] SETUP_ADDR = 12'h008,
    parameter logic [RA_W-1:0] CMD_ADDR   = 12'h004,
    parameter int              ST_W       = 5,
    parameter logic [ST_W-1:0] L0_CODE    = 5'h11
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [BUS_W-1:0]   req_bus,
    input logic               acc_valid,
    input logic               acc_remote,
    input logic [AW-1:0]      acc_addr,
    input logic [DW-1:0]      acc_setup,
    input logic               reg_rd,
    input logic               reg_wr,
    input logic [RA_W-1:0]    reg_addr,
    input logic [DW-1:0]      reg_wdata,
    input logic [DW-1:0]      reg_rdata,
    input logic [DW-1:0]      dbg_status,
    input logic               train_en,
    input logic               link_up,
    input logic [DW-1:0]      setup_q
);
    a_r1_local_keeps_setup: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && req_valid && req_bus == '0 |=> $stable(setup_q));

    a_r1_local_zero_setup: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_remote |-> acc_setup == '0);

    a_r3_type_bit: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_remote |->
            acc_setup[TYPE1_BIT] == (acc_setup[BUS_LSB +: BUS_W] > BUS_W'(1)));

    a_r5_dword_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> acc_addr[1:0] == 2'b00);

    a_r7_issue_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && req_valid |=> ##1 acc_valid);

    a_r7_setup_leads: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_remote |-> $past(setup_q) == acc_setup);

    a_r8_read_old_setup: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && reg_rd && reg_addr == SETUP_ADDR |=> reg_rdata == $past(setup_q));

    a_r8_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && reg_wr && reg_addr == SETUP_ADDR && !req_valid |=> $stable(setup_q));

    a_r9_train_write: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && reg_wr && reg_addr == CMD_ADDR |=> train_en == $past(reg_wdata[0]));

    a_r10_link_up: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && dbg_status[ST_W-1:0] == L0_CODE |=> link_up);

    a_r10_link_down: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && dbg_status[ST_W-1:0] != L0_CODE |=> !link_up);
endmodule

bind cfg_access_router cfgr_chk #(
    .RA_W(RA_W), .SETUP_ADDR(SETUP_ADDR), .CMD_ADDR(CMD_ADDR),
    .ST_W(ST_W), .L0_CODE(L0_CODE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_bus    (req_bus),
    .acc_valid  (acc_valid),
    .acc_remote (acc_remote),
    .acc_addr   (acc_addr),
    .acc_setup  (acc_setup),
    .reg_rd     (reg_rd),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .dbg_status (dbg_status),
    .train_en   (train_en),
    .link_up    (link_up),
    .setup_q    (setup_q)
);

// File: tb/sim_cfg_access_router.sv
// Bench: behavioural reference model advanced on every rising edge and
// compared with the outputs on every falling edge, plus directed checks.
module sim_cfg_access_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [7:0]  req_dev = '0;
    logic [7:0]  req_fn = '0;
    logic [11:0] req_off = '0;
    logic        acc_valid, acc_remote;
    logic [31:0] acc_addr, acc_setup;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] dbg_status = '0;
    logic        train_en, link_up;

    int errors = 0;
    int checks = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    cfg_access_router u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bus(req_bus),
        .req_dev(req_dev), .req_fn(req_fn), .req_off(req_off),
        .acc_valid(acc_valid), .acc_remote(acc_remote), .acc_addr(acc_addr),
        .acc_setup(acc_setup), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dbg_status(dbg_status), .train_en(train_en), .link_up(link_up)
    );

    // ---------------- reference model ----------------
    typedef struct packed {
        logic        v;
        logic        remote;
        logic [31:0] addr;
        logic [31:0] setup;
    } ent_t;

    ent_t        pipe_q[$];
    ent_t        m_out;
    logic [31:0] m_setup, m_rdata;
    logic        m_train, m_link;

    initial begin
        pipe_q.push_back('0);
        m_out = '0; m_setup = '0; m_rdata = '0; m_train = 1'b0; m_link = 1'b0;
    end

    always @(posedge clk) begin
        ent_t e;
        int   b;
        b = int'(req_bus);
        if (!rst_n) begin
            pipe_q = {};
            pipe_q.push_back('0);
            m_out = '0; m_setup = '0; m_rdata = '0; m_train = 1'b0; m_link = 1'b0;
        end else begin
            if (reg_rd) begin
                if (reg_addr == 12'h008)      m_rdata = m_setup;
                else if (reg_addr == 12'h004) m_rdata = {31'd0, m_train};
                else                          m_rdata = '0;
            end
            if (reg_wr && reg_addr == 12'h004) m_train = reg_wdata[0];
            m_link = (dbg_status % 32) == 17;
            m_out = pipe_q.pop_front();
            e = '0;
            if (req_valid) begin
                e.v = 1'b1;
                e.remote = (b != 0);
                e.addr = (b != 0 ? 32'h1000 : 32'h0) + ((int'(req_off) / 4) * 4);
                if (b != 0) begin
                    e.setup = (b * 65536) + ((int'(req_dev) % 32) * 256) + (int'(req_fn) % 8);
                    if (b >= 2) e.setup = e.setup + 32'h0100_0000;
                    m_setup = e.setup;
                end
            end
            pipe_q.push_back(e);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R7 acc_valid", {31'd0, acc_valid}, {31'd0, m_out.v});
            chk("R1 acc_remote", {31'd0, acc_remote}, {31'd0, m_out.remote});
            chk("R4 acc_addr", acc_addr, m_out.addr);
            chk("R2 acc_setup", acc_setup, m_out.setup);
            chk("R8 reg_rdata", reg_rdata, m_rdata);
            chk("R9 train_en", {31'd0, train_en}, {31'd0, m_train});
            chk("R10 link_up", {31'd0, link_up}, {31'd0, m_link});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic send(input logic [7:0] b, input logic [7:0] d,
                        input logic [7:0] f, input logic [11:0] o);
        @(negedge clk);
        req_valid = 1'b1; req_bus = b; req_dev = d; req_fn = f; req_off = o;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_acc(input string tag, input logic rem,
                              input logic [31:0] a, input logic [31:0] s);
        @(negedge clk);
        chk({tag, " valid"}, {31'd0, acc_valid}, 32'd1);
        chk({tag, " region"}, {31'd0, acc_remote}, {31'd0, rem});
        chk({tag, " addr"}, acc_addr, a);
        chk({tag, " setup"}, acc_setup, s);
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Watchdog: a hang is a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        dbg_status = 32'h0000_0011;
        repeat (3) @(negedge clk);
        // R11: reset state, even with link state active on the input
        chk("R11 acc_valid", {31'd0, acc_valid}, 32'd0);
        chk("R11 acc_addr", acc_addr, 32'd0);
        chk("R11 acc_setup", acc_setup, 32'd0);
        chk("R11 reg_rdata", reg_rdata, 32'd0);
        chk("R11 train_en", {31'd0, train_en}, 32'd0);
        chk("R11 link_up", {31'd0, link_up}, 32'd0);
        dbg_status = '0;
        rst_n = 1'b1;
        cmp_on = 1'b1;

        // R1/R5: local access with an unaligned offset
        send(8'd0, 8'd3, 8'd2, 12'h013);
        expect_acc("R1 local", 1'b0, 32'h0000_0010, 32'h0);
        rd(12'h008, v);
        chk("R1 setup untouched", v, 32'h0);

        // R2/R3: bus 1 uses Type 0
        send(8'd1, 8'h1F, 8'h07, 12'h0FF);
        expect_acc("R3 bus1 type0", 1'b1, 32'h0000_10FC, 32'h0001_1F07);

        // R6/R3/R4: masked ids, Type 1 on bus 5
        send(8'd5, 8'h25, 8'h0A, 12'h103);
        expect_acc("R6 masked type1", 1'b1, 32'h0000_1100, 32'h0105_0502);
        rd(12'h008, v);
        chk("R8 setup read", v, 32'h0105_0502);

        // R8: write to the setup offset is ignored
        wr(12'h008, 32'hDEAD_BEEF);
        rd(12'h008, v);
        chk("R8 write ignored", v, 32'h0105_0502);

        // R8/R7: read and remote request in the same cycle
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 12'h008;
        req_valid = 1'b1; req_bus = 8'd2; req_dev = 8'd1; req_fn = 8'd1; req_off = 12'h000;
        @(negedge clk);
        reg_rd = 1'b0; req_valid = 1'b0;
        chk("R8 same-cycle read old", reg_rdata, 32'h0105_0502);
        chk("R7 output not yet", {31'd0, acc_valid}, 32'd0);
        @(negedge clk);
        chk("R7 output one edge later", {31'd0, acc_valid}, 32'd1);
        chk("R2 bus2 setup", acc_setup, 32'h0102_0101);
        rd(12'h008, v);
        chk("R8 new setup read", v, 32'h0102_0101);

        // R7: back-to-back requests
        @(negedge clk);
        req_valid = 1'b1; req_bus = 8'd0; req_off = 12'h004;
        @(negedge clk);
        req_bus = 8'd7; req_dev = 8'd9; req_fn = 8'd3; req_off = 12'hFFF;
        @(negedge clk);
        req_bus = 8'd1; req_dev = 8'd0; req_fn = 8'd0; req_off = 12'h040;
        chk("R7 b2b first local", {30'd0, acc_valid, acc_remote}, 32'd2);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R5 b2b max offset", acc_addr, 32'h0000_1FFC);
        chk("R3 b2b bus7", acc_setup, 32'h0107_0903);
        @(negedge clk);
        chk("R7 b2b third", {30'd0, acc_valid, acc_remote}, 32'd3);
        @(negedge clk);
        chk("R7 single pulse", {31'd0, acc_valid}, 32'd0);

        // R3: highest bus number
        send(8'hFF, 8'd0, 8'd0, 12'h000);
        expect_acc("R3 bus255", 1'b1, 32'h0000_1000, 32'h01FF_0000);

        // R9: command bit 0
        wr(12'h004, 32'hFFFF_FFFF);
        chk("R9 train set", {31'd0, train_en}, 32'd1);
        rd(12'h004, v);
        chk("R9 cmd readback", v, 32'd1);
        wr(12'h004, 32'h0000_0000);
        chk("R9 train clear", {31'd0, train_en}, 32'd0);
        rd(12'h010, v);
        chk("R8 unused offset", v, 32'd0);

        // R10: link sensing
        @(negedge clk); dbg_status = 32'h0000_0011;
        @(negedge clk); chk("R10 up", {31'd0, link_up}, 32'd1);
        dbg_status = 32'hFFFF_FFF1;
        @(negedge clk); chk("R10 upper bits ignored", {31'd0, link_up}, 32'd1);
        dbg_status = 32'h0000_0012;
        @(negedge clk); chk("R10 down", {31'd0, link_up}, 32'd0);

        // R11: reset mid-run clears setup register
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(12'h008, v);
        chk("R11 setup cleared", v, 32'd0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule